// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block lets a host reach a separate 32-bit register space through four word registers. The four registers sit at a fixed base inside the host's memory-mapped region. The host loads a target address, and for a write also the data. It then writes a command word requesting a read or a write. The bridge performs exactly one transfer on a downstream request/ready register bus. When the transfer finishes it sets an acknowledge flag in the command word, and for a read it holds the fetched value in the read-data register.

The host polls the command word until the acknowledge flag appears, collects any read data, and then writes zero to the command word. That write returns the bridge to idle, and the command word reads back as exactly zero again. Inside one host transaction the bridge is strictly sequential: one downstream transfer is outstanding at a time, and the registers that describe it are frozen until it completes. Commands that cannot be carried out are acknowledged at once and never reach the downstream bus. These are commands with both request bits set and commands whose target lies outside the downstream range.

Top module: `reg_window_bridge`

## Requirements
- R1: After reset all four window registers read zero and no downstream request is active.
- R2: The window layout, relative to the window base (default 0x400), is: command at +0x0, address at +0x4, read data at +0x8, write data at +0xC. Address and write-data values written by the host read back unchanged. A host read returns its data with `h_rvalid_o` on the clock edge that samples `h_rd_i`. A read outside the window, or at an address that is not word aligned, returns zero.
- R3: A command value of 0x2 (bit 1 = write) starts one downstream write with `ds_we_o`=1 and the stored address and write data. `ds_req_o` stays high, with stable address and data, until `ds_ready_i` is seen, and exactly one transfer completes.
- R4: A command value of 0x1 (bit 0 = read) starts one downstream read, and the value returned with `ds_ready_i` is placed in the read-data register.
- R5: On completion, bit 2 (acknowledge) of the command word is set in the cycle after the ready handshake, next to the request bit. A finished read therefore reads 0x5 and a finished write reads 0x6. No downstream request is active while the acknowledge bit is set.
- R6: Writing 0x0 to the command word while the acknowledge bit is set returns the bridge to idle, and the command word then reads 0x0.
- R7: While a transfer is pending and not yet acknowledged, host writes to the command, address and write-data registers are ignored.
- R8: A command value of 0x3 (both request bits) is acknowledged at once: the command word reads 0x7, no downstream transfer happens, and the read-data register becomes zero.
- R9: A command whose stored address is above the downstream limit (default 0xFFF) is acknowledged with no downstream transfer. For a read, the read-data register becomes zero.
- R10: Command writes that would start nothing are ignored. This covers a non-zero command write while the acknowledge bit is set, and a write in idle that sets neither bit 0 nor bit 1.
- R11: Host writes to the read-data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_wr_i | input | 1 | Host write strobe |
| h_rd_i | input | 1 | Host read strobe |
| h_addr_i | input | HOST_AW | Host byte address |
| h_wdata_i | input | DW | Host write data |
| h_rdata_o | output | DW | Host read data |
| h_rvalid_o | output | 1 | Host read data valid |
| ds_req_o | output | 1 | Downstream request, held until ready |
| ds_we_o | output | 1 | Downstream write enable |
| ds_addr_o | output | DW | Downstream register address |
| ds_wdata_o | output | DW | Downstream write data |
| ds_rdata_i | input | DW | Downstream read data |
| ds_ready_i | input | 1 | Downstream transfer complete |

## Verification
The bench targets the window's protocol corners. One case rewrites the address and clears the command while a slow transfer is still pending; a bridge without the freeze would retarget the bus or drop the acknowledge. Another case sends a command with both request bits set, and a separate case targets an address above the limit; a bridge that decodes these badly would issue a stray downstream access or leave stale read data behind. Further cases cover non-zero command writes after the acknowledge, host writes to the read-data register, and varied slave latencies. A bridge that mishandled any of these would re-issue a transfer, corrupt the read result, or sample read data on the wrong cycle.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam int NUM_REGS = 4;
  // word index inside the window
  localparam int IDX_CMD  = 0;
  localparam int IDX_ADDR = 1;
  localparam int IDX_RDAT = 2;
  localparam int IDX_WDAT = 3;
  // command word bits
  localparam int BIT_RD   = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_ACK  = 2;
  localparam int CMD_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } bstate_e;
endpackage

// File: rtl/rwb_host_if.sv
module rwb_host_if
  import rwb_pkg::*;
#(
  parameter int          HOST_AW  = 12,
  parameter int          DW       = 32,
  parameter logic [31:0] WIN_BASE = 32'h400
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          h_wr_i,
  input  logic                          h_rd_i,
  input  logic [HOST_AW-1:0]            h_addr_i,
  input  logic [NUM_REGS-1:0][DW-1:0]   regs_i,
  output logic [NUM_REGS-1:0]           wr_sel_o,
  output logic [DW-1:0]                 h_rdata_o,
  output logic                          h_rvalid_o
);
  localparam int IDX_W   = $clog2(NUM_REGS);
  localparam int LSB     = 2;
  localparam int TAG_LSB = LSB + IDX_W;
  localparam logic [HOST_AW-1:0] BASE = WIN_BASE[HOST_AW-1:0];

  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = (h_addr_i[HOST_AW-1:TAG_LSB] == BASE[HOST_AW-1:TAG_LSB]) &&
               (h_addr_i[LSB-1:0] == '0);
  assign idx = h_addr_i[TAG_LSB-1:LSB];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel_o[g] = h_wr_i && hit && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_rdata_o  <= '0;
      h_rvalid_o <= 1'b0;
    end else begin
      h_rvalid_o <= h_rd_i;
      if (h_rd_i) h_rdata_o <= hit ? regs_i[idx] : '0;
    end
  end
endmodule

// File: rtl/rwb_cmd_fsm.sv
module rwb_cmd_fsm
  import rwb_pkg::*;
#(
  parameter int          DW     = 32,
  parameter logic [31:0] DS_MAX = 32'hFFF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] wr_sel_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [CMD_W-1:0]    cmd_o,
  output logic [DW-1:0]       addr_o,
  output logic [DW-1:0]       wdat_o,
  output logic [DW-1:0]       rdat_o,
  output logic                ds_req_o,
  output logic                ds_we_o,
  input  logic [DW-1:0]       ds_rdata_i,
  input  logic                ds_ready_i
);
  localparam logic [DW-1:0] LIMIT = DW'(DS_MAX);

  bstate_e          state_q;
  logic [CMD_W-1:0] cmd_q;
  logic [DW-1:0]    addr_q, wdat_q, rdat_q;
  logic [1:0]       op;

  assign op = wdata_i[BIT_WR:BIT_RD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
    end else begin
      // operand registers frozen while a transfer is in flight
      if (state_q != ST_BUSY) begin
        if (wr_sel_i[IDX_ADDR]) addr_q <= wdata_i;
        if (wr_sel_i[IDX_WDAT]) wdat_q <= wdata_i;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (wr_sel_i[IDX_CMD] && (op != 2'b00)) begin
            if (op == 2'b11) begin
              cmd_q   <= {1'b1, op};
              rdat_q  <= '0;
              state_q <= ST_DONE;
            end else if (addr_q > LIMIT) begin
              cmd_q   <= {1'b1, op};
              if (op[BIT_RD]) rdat_q <= '0;
              state_q <= ST_DONE;
            end else begin
              cmd_q   <= {1'b0, op};
              state_q <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (ds_ready_i) begin
            cmd_q[BIT_ACK] <= 1'b1;
            if (cmd_q[BIT_RD]) rdat_q <= ds_rdata_i;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (wr_sel_i[IDX_CMD] && (wdata_i == '0)) begin
            cmd_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ds_req_o = (state_q == ST_BUSY);
  assign ds_we_o  = cmd_q[BIT_WR];
  assign cmd_o    = cmd_q;
  assign addr_o   = addr_q;
  assign wdat_o   = wdat_q;
  assign rdat_o   = rdat_q;
endmodule

// File: rtl/reg_window_bridge.sv
module reg_window_bridge
  import rwb_pkg::*;
#(
  parameter int          HOST_AW  = 12,
  parameter int          DW       = 32,
  parameter logic [31:0] WIN_BASE = 32'h400,
  parameter logic [31:0] DS_MAX   = 32'hFFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               h_wr_i,
  input  logic               h_rd_i,
  input  logic [HOST_AW-1:0] h_addr_i,
  input  logic [DW-1:0]      h_wdata_i,
  output logic [DW-1:0]      h_rdata_o,
  output logic               h_rvalid_o,
  output logic               ds_req_o,
  output logic               ds_we_o,
  output logic [DW-1:0]      ds_addr_o,
  output logic [DW-1:0]      ds_wdata_o,
  input  logic [DW-1:0]      ds_rdata_i,
  input  logic               ds_ready_i
);
  logic [NUM_REGS-1:0]         wr_sel;
  logic [NUM_REGS-1:0][DW-1:0] reg_view;
  logic [CMD_W-1:0]            cmd_q;
  logic [DW-1:0]               cmd_word, addr_q, wdat_q, rdat_q;

  assign cmd_word           = DW'(cmd_q);
  assign reg_view[IDX_CMD]  = cmd_word;
  assign reg_view[IDX_ADDR] = addr_q;
  assign reg_view[IDX_RDAT] = rdat_q;
  assign reg_view[IDX_WDAT] = wdat_q;

  rwb_host_if #(.HOST_AW(HOST_AW), .DW(DW), .WIN_BASE(WIN_BASE)) u_host (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .h_wr_i     (h_wr_i),
    .h_rd_i     (h_rd_i),
    .h_addr_i   (h_addr_i),
    .regs_i     (reg_view),
    .wr_sel_o   (wr_sel),
    .h_rdata_o  (h_rdata_o),
    .h_rvalid_o (h_rvalid_o)
  );

  rwb_cmd_fsm #(.DW(DW), .DS_MAX(DS_MAX)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_sel_i   (wr_sel),
    .wdata_i    (h_wdata_i),
    .cmd_o      (cmd_q),
    .addr_o     (addr_q),
    .wdat_o     (wdat_q),
    .rdat_o     (rdat_q),
    .ds_req_o   (ds_req_o),
    .ds_we_o    (ds_we_o),
    .ds_rdata_i (ds_rdata_i),
    .ds_ready_i (ds_ready_i)
  );

  assign ds_addr_o  = addr_q;
  assign ds_wdata_o = wdat_q;
endmodule

// File: rtl/reg_window_bridge_chk.sv
module reg_window_bridge_chk #(
  parameter int          HOST_AW  = 12,
  parameter int          DW       = 32,
  parameter logic [31:0] WIN_BASE = 32'h400,
  parameter logic [31:0] DS_MAX   = 32'hFFF
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               h_wr_i,
  input logic               h_rd_i,
  input logic [HOST_AW-1:0] h_addr_i,
  input logic [DW-1:0]      h_wdata_i,
  input logic               h_rvalid_o,
  input logic               ds_req_o,
  input logic               ds_we_o,
  input logic [DW-1:0]      ds_addr_o,
  input logic [DW-1:0]      ds_wdata_o,
  input logic               ds_ready_i,
  input logic [DW-1:0]      cmd_word
);
  localparam logic [HOST_AW-1:0] CMD_ADDR = WIN_BASE[HOST_AW-1:0];

  assert_rvalid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_rd_i |=> h_rvalid_o);

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o && !ds_ready_i |=> ds_req_o && $stable(ds_we_o) && $stable(ds_addr_o)
                                && $stable(ds_wdata_o));

  assert_ack_after_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o && ds_ready_i |=> cmd_word[2] && !ds_req_o);

  assert_no_req_when_acked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_word[2] |-> !ds_req_o);

  assert_clear_to_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_wr_i && (h_addr_i == CMD_ADDR) && (h_wdata_i == '0) && cmd_word[2]
    |=> cmd_word == '0);

  assert_frozen_while_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o |=> $stable(ds_addr_o) && $stable(ds_wdata_o) && $stable(cmd_word[1:0]));

  assert_invalid_no_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_word[1:0] == 2'b11) |-> !ds_req_o);

  assert_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o |-> ds_addr_o <= DW'(DS_MAX));
endmodule

bind reg_window_bridge reg_window_bridge_chk #(
  .HOST_AW(HOST_AW), .DW(DW), .WIN_BASE(WIN_BASE), .DS_MAX(DS_MAX)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .h_wr_i     (h_wr_i),
  .h_rd_i     (h_rd_i),
  .h_addr_i   (h_addr_i),
  .h_wdata_i  (h_wdata_i),
  .h_rvalid_o (h_rvalid_o),
  .ds_req_o   (ds_req_o),
  .ds_we_o    (ds_we_o),
  .ds_addr_o  (ds_addr_o),
  .ds_wdata_o (ds_wdata_o),
  .ds_ready_i (ds_ready_i),
  .cmd_word   (cmd_word)
);

// File: tb/reg_window_bridge_test.sv
`timescale 1ns/1ps
module reg_window_bridge_test;
  localparam logic [11:0] A_CMD  = 12'h400;
  localparam logic [11:0] A_ADDR = 12'h404;
  localparam logic [11:0] A_RDAT = 12'h408;
  localparam logic [11:0] A_WDAT = 12'h40C;

  // {is_read, latency, address, data (write value or expected read)}
  localparam int NVEC = 8;
  localparam logic [67:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 32'h0000_0010, 32'hDEAD_BEEF},
    {1'b0, 3'd3, 32'h0000_07FC, 32'h1234_5678},
    {1'b0, 3'd1, 32'h0000_0000, 32'hA5A5_0F0F},
    {1'b0, 3'd5, 32'h0000_0FFC, 32'h8000_0001},
    {1'b1, 3'd2, 32'h0000_07FC, 32'h1234_5678},
    {1'b1, 3'd0, 32'h0000_0010, 32'hDEAD_BEEF},
    {1'b1, 3'd4, 32'h0000_0FFC, 32'h8000_0001},
    {1'b1, 3'd1, 32'h0000_0020, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [11:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        h_rvalid;
  logic        ds_req, ds_we, ds_ready;
  logic [31:0] ds_addr, ds_wdata, ds_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  reg_window_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .h_wr_i(h_wr), .h_rd_i(h_rd), .h_addr_i(h_addr),
    .h_wdata_i(h_wdata), .h_rdata_o(h_rdata), .h_rvalid_o(h_rvalid),
    .ds_req_o(ds_req), .ds_we_o(ds_we), .ds_addr_o(ds_addr), .ds_wdata_o(ds_wdata),
    .ds_rdata_i(ds_rdata), .ds_ready_i(ds_ready)
  );

  // downstream slave model
  logic [31:0] mem [1024];
  logic [2:0]  lat = 3'd0;
  int          wait_cnt = 0, ds_cnt = 0;
  logic        last_we = 1'b0;
  logic [31:0] last_addr = '0, last_wdata = '0;

  assign ds_ready = ds_req && (wait_cnt >= int'(lat));
  assign ds_rdata = mem[ds_addr[11:2]];

  initial for (int i = 0; i < 1024; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (ds_req) begin
      if (ds_ready) begin
        wait_cnt   <= 0;
        ds_cnt     <= ds_cnt + 1;
        last_we    <= ds_we;
        last_addr  <= ds_addr;
        last_wdata <= ds_wdata;
        if (ds_we) mem[ds_addr[11:2]] <= ds_wdata;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(posedge clk); #1;
    h_wr = 1'b0;
  endtask

  logic last_rv;
  task automatic host_read(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    h_rd = 1'b1; h_addr = a;
    @(posedge clk); #1;
    v = h_rdata; last_rv = h_rvalid;
    h_rd = 1'b0;
  endtask

  task automatic poll_ack(output logic [31:0] v);
    for (int k = 0; k < 64; k++) begin
      host_read(A_CMD, v);
      if (v[2]) break;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base_cnt;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk("R1 ds_req", {31'b0, ds_req}, 32'h0);
    host_read(A_CMD, v);  chk("R1 cmd", v, 32'h0);
    host_read(A_ADDR, v); chk("R1 addr", v, 32'h0);
    host_read(A_RDAT, v); chk("R1 rdat", v, 32'h0);
    host_read(A_WDAT, v); chk("R1 wdat", v, 32'h0);

    // R2: layout, readback, rvalid, out-of-window and misaligned reads
    host_write(A_ADDR, 32'h0000_0ABC);
    host_write(A_WDAT, 32'hCAFE_F00D);
    host_read(A_ADDR, v); chk("R2 addr readback", v, 32'h0000_0ABC);
    chk("R2 rvalid", {31'b0, last_rv}, 32'h1);
    host_read(A_WDAT, v); chk("R2 wdat readback", v, 32'hCAFE_F00D);
    host_read(12'h004, v); chk("R2 outside window", v, 32'h0);
    host_read(12'h406, v); chk("R2 misaligned", v, 32'h0);

    // R11: read-data register ignores host writes
    host_write(A_RDAT, 32'h5555_AAAA);
    host_read(A_RDAT, v); chk("R11 rdat write ignored", v, 32'h0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      logic        is_rd;
      logic [31:0] va, vd;
      is_rd = VEC[i][67];
      lat   = VEC[i][66:64];
      va    = VEC[i][63:32];
      vd    = VEC[i][31:0];
      base_cnt = ds_cnt;
      if (!is_rd) begin
        host_write(A_WDAT, vd);
        host_write(A_ADDR, va);
        host_write(A_CMD, 32'h2);
        poll_ack(v);
        chk("R5 write ack word", v, 32'h6);
        chk("R3 one transfer", ds_cnt - base_cnt, 32'h1);
        chk("R3 we", {31'b0, last_we}, 32'h1);
        chk("R3 addr", last_addr, va);
        chk("R3 data", last_wdata, vd);
      end else begin
        host_write(A_ADDR, va);
        host_write(A_CMD, 32'h1);
        poll_ack(v);
        chk("R5 read ack word", v, 32'h5);
        chk("R4 one transfer", ds_cnt - base_cnt, 32'h1);
        host_read(A_RDAT, v);
        chk("R4 read data", v, vd);
      end
      host_write(A_CMD, 32'h0);
      host_read(A_CMD, v); chk("R6 cleared", v, 32'h0);
    end

    // R7: writes during a pending transfer are ignored
    lat = 3'd7;
    host_write(A_WDAT, 32'h0BAD_0BAD);
    host_write(A_ADDR, 32'h0000_07FC);
    base_cnt = ds_cnt;
    host_write(A_CMD, 32'h1);
    host_write(A_ADDR, 32'h0000_0020);
    host_write(A_CMD, 32'h0);
    host_write(A_WDAT, 32'h1111_2222);
    host_read(A_CMD, v); chk("R7 still pending", v, 32'h1);
    poll_ack(v);
    chk("R7 ack kept", v, 32'h5);
    chk("R7 target kept", last_addr, 32'h0000_07FC);
    chk("R7 one transfer", ds_cnt - base_cnt, 32'h1);
    host_read(A_RDAT, v); chk("R7 read data", v, 32'h1234_5678);
    host_read(A_ADDR, v); chk("R7 addr frozen", v, 32'h0000_07FC);
    host_read(A_WDAT, v); chk("R7 wdat frozen", v, 32'h0BAD_0BAD);

    // R10: non-zero command while acknowledged is ignored
    host_write(A_CMD, 32'h2);
    host_read(A_CMD, v); chk("R10 acked cmd kept", v, 32'h5);
    chk("R10 no new transfer", ds_cnt - base_cnt, 32'h1);
    host_write(A_CMD, 32'h0);
    host_read(A_CMD, v); chk("R6 cleared after R7", v, 32'h0);

    // R10: idle write without a request bit is ignored
    lat = 3'd0;
    base_cnt = ds_cnt;
    host_write(A_CMD, 32'h4);
    host_read(A_CMD, v); chk("R10 ack-only ignored", v, 32'h0);
    chk("R10 no transfer", ds_cnt - base_cnt, 32'h0);

    // R8: both request bits
    host_write(A_ADDR, 32'h0000_0010);
    host_write(A_CMD, 32'h1);
    poll_ack(v);
    host_write(A_CMD, 32'h0);
    base_cnt = ds_cnt;
    host_write(A_CMD, 32'h3);
    host_read(A_CMD, v); chk("R8 immediate ack", v, 32'h7);
    chk("R8 no transfer", ds_cnt - base_cnt, 32'h0);
    host_read(A_RDAT, v); chk("R8 read data zero", v, 32'h0);
    host_write(A_CMD, 32'h0);

    // R9: out-of-range address
    host_write(A_ADDR, 32'h0000_0010);
    host_write(A_CMD, 32'h1);
    poll_ack(v);
    host_write(A_CMD, 32'h0);
    base_cnt = ds_cnt;
    host_write(A_ADDR, 32'h0000_1000);
    host_write(A_CMD, 32'h2);
    host_read(A_CMD, v); chk("R9 write ack", v, 32'h6);
    host_write(A_CMD, 32'h0);
    host_write(A_CMD, 32'h1);
    host_read(A_CMD, v); chk("R9 read ack", v, 32'h5);
    chk("R9 no transfer", ds_cnt - base_cnt, 32'h0);
    host_read(A_RDAT, v); chk("R9 read data zero", v, 32'h0);
    host_write(A_CMD, 32'h0);
    host_read(A_CMD, v); chk("R6 cleared after R9", v, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule